// File: doc/BRIEF.md
# Supervisor Trap Delegation Unit

This block sits next to a hart's machine-level trap logic and decides, for every trap the pipeline raises, which privilege level services it. Interrupts and exceptions each have their own per-cause delegation mask. A trap whose mask bit is set, and which arises while the hart runs below machine level, is taken at supervisor level. Such a trap is handled entirely inside this block. The block holds the supervisor trap state (status bits, interrupt enables, handler base, return address, cause and fault value), performs the supervisor entry and returns the redirect target and new privilege to the fetch stage.

Traps that are not delegated are reported to the machine-level unit through a single strobe. On that path the block leaves its own state untouched. A supervisor-return strobe sends the hart back to the saved return address, at the privilege recorded at entry. All registers are readable and writable through a small selector-addressed CSR port with combinational read data.

Top module: `deleg_trap_unit`

## Requirements
- R1: An interrupt (trap_irq=1) with cause code c, raised at user (cur_priv=0) or supervisor (cur_priv=1) level, goes to supervisor level (tgt_priv=1) when bit c of the interrupt mask is set, and otherwise to machine level (tgt_priv=3). Code 9 is the supervisor external interrupt and is routed by bit 9.
- R2: An exception (trap_irq=0) with cause code c is routed the same way by bit c of the exception mask. Environment calls use codes 8 (user), 9 (supervisor) and 11 (machine). Bit 11 of the exception mask is hardwired to 0.
- R3: A trap raised while cur_priv=3 always goes to machine level, whatever the masks hold. Every trap routed to machine level raises mtrap_fire, keeps redir_valid at 0, drives new_priv=3 and leaves all supervisor registers unchanged.
- R4: On a delegated trap, in the same cycle: redir_valid=1 and new_priv=1. redir_pc is the handler base (stvec with bits 1:0 cleared). When the mode bit (stvec bit 0) is 1 and the trap is an interrupt, redir_pc is base + 4*code instead.
- R5: After the clock edge that takes a delegated trap, the following hold. The return address register holds trap_pc. The cause register holds trap_irq in bit 31 and the code in its low bits. The fault register holds trap_tval.
- R6: Supervisor status layout is SIE in bit 1, SPIE in bit 5 and SPP in bit 8. Delegated entry copies SIE into SPIE and clears SIE. It sets SPP to 1 when entered from supervisor level and to 0 when entered from user level.
- R7: While sret_req=1 and trap_req=0, the block drives redir_valid=1, redir_pc = the return address register and new_priv = SPP. After that edge SIE takes the old SPIE, SPIE becomes 1 and SPP becomes 0.
- R8: When trap_req and sret_req are both 1, the trap is taken and the return is ignored.
- R9: CSR selector map: 0 exception mask, 1 interrupt mask, 2 status, 3 interrupt enable, 4 handler base, 5 return address, 6 cause, 7 fault value. Writable bits per register:
  - Status: only bits 1, 5 and 8.
  - Interrupt enable: only bits 1, 5 and 9.
  - Handler base: bit 1 reads 0.
  - Return address: bit 0 reads 0.
  - Masks: 16 bits wide.
  - Cause and fault value: fully writable.
  - All registers reset to 0.
- R10: A CSR write that lands in the same cycle as a delegated trap loses to the trap on every register the trap updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | A trap is raised this cycle |
| trap_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | 4 | Cause code |
| trap_tval | input | 32 | Fault value for the trap |
| trap_pc | input | 32 | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| sret_req | input | 1 | Supervisor return strobe |
| csr_we | input | 1 | CSR write enable |
| csr_sel | input | 3 | CSR selector (map in R9) |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for csr_sel |
| tgt_priv | output | 2 | Level chosen for the current trap |
| mtrap_fire | output | 1 | Trap handed to the machine-level unit |
| redir_valid | output | 1 | This block redirects fetch this cycle |
| redir_pc | output | 32 | Redirect target |
| new_priv | output | 2 | Privilege after this cycle's event |

## Verification
The bench sweeps all 16 cause codes, both trap kinds and the three privilege levels, under two mask pairs. This separates the interrupt mask from the exception mask, and it separates the machine-level override from a cleared mask bit. One sweep uses the direct handler mode and one the per-cause mode, so an interrupt offset that leaks into exceptions or direct mode shows up. The status bits are preset from the cause code before each trap, and every delegated trap is followed by a return. This drives each SIE/SPIE/SPP combination through entry and return. Separate cases cover the simultaneous trap and return, a CSR write racing a trap, and the read-only and write-masked bits.

// File: rtl/strap_pkg.sv
// Package: shared constants and types for the supervisor trap delegation unit.
// Assumes privilege encoding 0 = user, 1 = supervisor, 3 = machine.
package strap_pkg;
    typedef enum logic [2:0] {
        SEL_EDELEG  = 3'd0,
        SEL_IDELEG  = 3'd1,
        SEL_SSTATUS = 3'd2,
        SEL_SIE     = 3'd3,
        SEL_STVEC   = 3'd4,
        SEL_SEPC    = 3'd5,
        SEL_SCAUSE  = 3'd6,
        SEL_STVAL   = 3'd7
    } csr_sel_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    // status bit positions (software visible)
    localparam int ST_SIE  = 1;
    localparam int ST_SPIE = 5;
    localparam int ST_SPP  = 8;

    // interrupt-enable bit positions (software, timer, external)
    localparam int IE_SW  = 1;
    localparam int IE_TMR = 5;
    localparam int IE_EXT = 9;

    // environment call from machine level can never be delegated
    localparam int ECALL_M_CODE = 11;

    typedef struct packed {
        logic sie;
        logic spie;
        logic spp;
    } sstat_t;
endpackage

// File: rtl/deleg_decide.sv
// Module: deleg_decide
// Purely combinational routing decision. A trap goes to supervisor level
// when the matching mask bit is set and the hart is not in machine level.
// Assumes NCAUSE is a power of two so every code indexes a mask bit.
module deleg_decide #(
    parameter int NCAUSE = 16,
    localparam int CODE_W = $clog2(NCAUSE)
) (
    input  logic              trap_req,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [1:0]        cur_priv,
    input  logic [NCAUSE-1:0] edeleg,
    input  logic [NCAUSE-1:0] ideleg,
    output logic              s_entry,
    output logic              m_entry
);
    import strap_pkg::*;

    logic mask_hit;
    logic from_m;

    // pick the mask bit for this cause and apply the machine-level override
    always_comb begin
        mask_hit = trap_irq ? ideleg[trap_code] : edeleg[trap_code];
        from_m   = (cur_priv == PRIV_M);
        s_entry  = trap_req && mask_hit && !from_m;
        m_entry  = trap_req && !(mask_hit && !from_m);
    end
endmodule

// File: rtl/scsr_file.sv
// Module: scsr_file
// Holds the delegation masks and supervisor trap registers, and applies
// supervisor entry, supervisor return and CSR writes. Priority on any
// register: trap entry, then return, then CSR write.
// Assumes s_entry and sret_go are never both high (the top guarantees it).
module scsr_file #(
    parameter int  XLEN   = 32,
    parameter int  NCAUSE = 16,
    parameter bit  VEC_EN = 1'b1,
    localparam int CODE_W = $clog2(NCAUSE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [2:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    input  logic              s_entry,
    input  logic              sret_go,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_tval,
    input  logic [1:0]        cur_priv,
    output logic [NCAUSE-1:0] edeleg_q,
    output logic [NCAUSE-1:0] ideleg_q,
    output logic [XLEN-3:0]   tvec_base,
    output logic              tvec_mode,
    output logic [XLEN-1:0]   sepc_q,
    output strap_pkg::sstat_t sstat_q
);
    import strap_pkg::*;

    localparam logic [NCAUSE-1:0] EDELEG_WMASK =
        ~({{(NCAUSE-1){1'b0}}, 1'b1} << ECALL_M_CODE);
    localparam int PAD_W = XLEN - 1 - CODE_W;

    csr_sel_e          sel;
    logic [2:0]        sie_q;
    logic [XLEN-1:0]   scause_q;
    logic [XLEN-1:0]   stval_q;

    assign sel = csr_sel_e'(csr_sel);

    // delegation masks: software writes only, machine ecall bit stays zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edeleg_q <= '0;
            ideleg_q <= '0;
        end else if (csr_we) begin
            if (sel == SEL_EDELEG) edeleg_q <= csr_wdata[NCAUSE-1:0] & EDELEG_WMASK;
            if (sel == SEL_IDELEG) ideleg_q <= csr_wdata[NCAUSE-1:0];
        end
    end

    // status bits: entry stacks SIE, return unstacks it, else CSR write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sstat_q <= '0;
        end else if (s_entry) begin
            sstat_q.spie <= sstat_q.sie;
            sstat_q.sie  <= 1'b0;
            sstat_q.spp  <= (cur_priv == PRIV_S);
        end else if (sret_go) begin
            sstat_q.sie  <= sstat_q.spie;
            sstat_q.spie <= 1'b1;
            sstat_q.spp  <= 1'b0;
        end else if (csr_we && sel == SEL_SSTATUS) begin
            sstat_q.sie  <= csr_wdata[ST_SIE];
            sstat_q.spie <= csr_wdata[ST_SPIE];
            sstat_q.spp  <= csr_wdata[ST_SPP];
        end
    end

    // interrupt enables and handler base: CSR writes only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sie_q     <= '0;
            tvec_base <= '0;
        end else if (csr_we) begin
            if (sel == SEL_SIE)
                sie_q <= {csr_wdata[IE_EXT], csr_wdata[IE_TMR], csr_wdata[IE_SW]};
            if (sel == SEL_STVEC)
                tvec_base <= csr_wdata[XLEN-1:2];
        end
    end

    // handler mode bit exists only when per-cause vectoring is built in
    generate
        if (VEC_EN) begin : g_vec
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tvec_mode <= 1'b0;
                else if (csr_we && sel == SEL_STVEC)
                    tvec_mode <= csr_wdata[0];
            end
        end else begin : g_novec
            assign tvec_mode = 1'b0;
        end
    endgenerate

    // trap record registers: entry has priority over CSR writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sepc_q   <= '0;
            scause_q <= '0;
            stval_q  <= '0;
        end else if (s_entry) begin
            sepc_q   <= trap_pc;
            scause_q <= {trap_irq, {PAD_W{1'b0}}, trap_code};
            stval_q  <= trap_tval;
        end else if (csr_we) begin
            if (sel == SEL_SEPC)   sepc_q   <= {csr_wdata[XLEN-1:1], 1'b0};
            if (sel == SEL_SCAUSE) scause_q <= csr_wdata;
            if (sel == SEL_STVAL)  stval_q  <= csr_wdata;
        end
    end

    // read mux
    always_comb begin
        csr_rdata = '0;
        case (sel)
            SEL_EDELEG:  csr_rdata[NCAUSE-1:0] = edeleg_q;
            SEL_IDELEG:  csr_rdata[NCAUSE-1:0] = ideleg_q;
            SEL_SSTATUS: begin
                csr_rdata[ST_SIE]  = sstat_q.sie;
                csr_rdata[ST_SPIE] = sstat_q.spie;
                csr_rdata[ST_SPP]  = sstat_q.spp;
            end
            SEL_SIE: begin
                csr_rdata[IE_SW]  = sie_q[0];
                csr_rdata[IE_TMR] = sie_q[1];
                csr_rdata[IE_EXT] = sie_q[2];
            end
            SEL_STVEC:   csr_rdata = {tvec_base, 1'b0, tvec_mode};
            SEL_SEPC:    csr_rdata = sepc_q;
            SEL_SCAUSE:  csr_rdata = scause_q;
            SEL_STVAL:   csr_rdata = stval_q;
            default:     csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tvec_target.sv
// Module: tvec_target
// Computes the fetch redirect: handler entry on a delegated trap (with a
// 4-byte-per-cause offset for interrupts in vectored mode), else sepc.
// Assumes the caller qualifies the result with its own valid.
module tvec_target #(
    parameter int  XLEN   = 32,
    parameter int  NCAUSE = 16,
    localparam int CODE_W = $clog2(NCAUSE)
) (
    input  logic              s_entry,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-3:0]   tvec_base,
    input  logic              tvec_mode,
    input  logic [XLEN-1:0]   sepc_q,
    output logic [XLEN-1:0]   redir_pc
);
    logic [XLEN-1:0] entry_pc;
    logic [XLEN-1:0] offset;

    // handler entry point, then choose between entry and return address
    always_comb begin
        offset   = (tvec_mode && trap_irq) ? (XLEN'(trap_code) << 2) : '0;
        entry_pc = {tvec_base, 2'b00} + offset;
        redir_pc = s_entry ? entry_pc : sepc_q;
    end
endmodule

// File: rtl/deleg_trap_unit.sv
// Module: deleg_trap_unit (top)
// Routes each trap to machine or supervisor level, performs supervisor
// entry and supervisor return, and exposes its registers on a CSR port.
// Assumes the pipeline only raises sret_req when the return is legal,
// and that trap_pc is instruction aligned.
module deleg_trap_unit #(
    parameter int  XLEN   = 32,
    parameter int  NCAUSE = 16,
    parameter bit  VEC_EN = 1'b1,
    localparam int CODE_W = $clog2(NCAUSE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_tval,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [1:0]        cur_priv,
    input  logic              sret_req,
    input  logic              csr_we,
    input  logic [2:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic [1:0]        tgt_priv,
    output logic              mtrap_fire,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_pc,
    output logic [1:0]        new_priv
);
    import strap_pkg::*;

    logic              s_entry;
    logic              m_entry;
    logic              sret_go;
    logic [NCAUSE-1:0] edeleg_q;
    logic [NCAUSE-1:0] ideleg_q;
    logic [XLEN-3:0]   tvec_base;
    logic              tvec_mode;
    logic [XLEN-1:0]   sepc_q;
    sstat_t            sstat_q;
    logic              sie_b;
    logic              spie_b;
    logic              spp_b;

    // a simultaneous trap wins over the return
    assign sret_go = sret_req && !trap_req;
    assign sie_b   = sstat_q.sie;
    assign spie_b  = sstat_q.spie;
    assign spp_b   = sstat_q.spp;

    deleg_decide #(.NCAUSE(NCAUSE)) u_decide (
        .trap_req (trap_req),
        .trap_irq (trap_irq),
        .trap_code(trap_code),
        .cur_priv (cur_priv),
        .edeleg   (edeleg_q),
        .ideleg   (ideleg_q),
        .s_entry  (s_entry),
        .m_entry  (m_entry)
    );

    scsr_file #(.XLEN(XLEN), .NCAUSE(NCAUSE), .VEC_EN(VEC_EN)) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_we   (csr_we),
        .csr_sel  (csr_sel),
        .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata),
        .s_entry  (s_entry),
        .sret_go  (sret_go),
        .trap_irq (trap_irq),
        .trap_code(trap_code),
        .trap_pc  (trap_pc),
        .trap_tval(trap_tval),
        .cur_priv (cur_priv),
        .edeleg_q (edeleg_q),
        .ideleg_q (ideleg_q),
        .tvec_base(tvec_base),
        .tvec_mode(tvec_mode),
        .sepc_q   (sepc_q),
        .sstat_q  (sstat_q)
    );

    tvec_target #(.XLEN(XLEN), .NCAUSE(NCAUSE)) u_target (
        .s_entry  (s_entry),
        .trap_irq (trap_irq),
        .trap_code(trap_code),
        .tvec_base(tvec_base),
        .tvec_mode(tvec_mode),
        .sepc_q   (sepc_q),
        .redir_pc (redir_pc)
    );

    // outcome signals for the fetch stage and the machine-level unit
    always_comb begin
        mtrap_fire  = m_entry;
        redir_valid = s_entry || sret_go;
        if (trap_req)
            tgt_priv = s_entry ? PRIV_S : PRIV_M;
        else
            tgt_priv = cur_priv;
        if (s_entry)
            new_priv = PRIV_S;
        else if (m_entry)
            new_priv = PRIV_M;
        else if (sret_go)
            new_priv = {1'b0, sstat_q.spp};
        else
            new_priv = cur_priv;
    end
endmodule

// File: rtl/deleg_trap_unit_chk.sv
// Module: deleg_trap_unit_chk
// Property checker bound into deleg_trap_unit; observes ports and the
// stored return address and status bits.
module deleg_trap_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_req,
    input logic [1:0]      cur_priv,
    input logic            sret_req,
    input logic [XLEN-1:0] trap_pc,
    input logic [1:0]      tgt_priv,
    input logic            mtrap_fire,
    input logic            redir_valid,
    input logic [XLEN-1:0] redir_pc,
    input logic [1:0]      new_priv,
    input logic [XLEN-1:0] sepc_q,
    input logic            sie_b,
    input logic            spie_b,
    input logic            spp_b
);
    // R3: machine-level traps stay at machine level
    a_r3_mmode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_priv == 2'd3) |-> (tgt_priv == 2'd3 && mtrap_fire && !redir_valid));

    // R3: a machine-routed trap never also redirects from this unit
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        mtrap_fire |-> (!redir_valid && new_priv == 2'd3));

    // R5: delegated trap records its PC
    a_r5_sepc_saved: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && tgt_priv == 2'd1) |=> (sepc_q == $past(trap_pc)));

    // R6: delegated entry stacks and clears SIE
    a_r6_sie_stacked: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && tgt_priv == 2'd1) |=> (!sie_b && spie_b == $past(sie_b)));

    // R7: return redirects to the saved address at the saved level
    a_r7_sret_target: assert property (@(posedge clk) disable iff (!rst_n)
        (sret_req && !trap_req) |-> (redir_valid && redir_pc == sepc_q && new_priv == {1'b0, spp_b}));

    // R7: return unstacks SIE
    a_r7_sret_state: assert property (@(posedge clk) disable iff (!rst_n)
        (sret_req && !trap_req) |=> (spie_b && !spp_b && sie_b == $past(spie_b)));
endmodule

bind deleg_trap_unit deleg_trap_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_req   (trap_req),
    .cur_priv   (cur_priv),
    .sret_req   (sret_req),
    .trap_pc    (trap_pc),
    .tgt_priv   (tgt_priv),
    .mtrap_fire (mtrap_fire),
    .redir_valid(redir_valid),
    .redir_pc   (redir_pc),
    .new_priv   (new_priv),
    .sepc_q     (sepc_q),
    .sie_b      (sie_b),
    .spie_b     (spie_b),
    .spp_b      (spp_b)
);

// File: tb/deleg_trap_unit_bench.sv
`timescale 1ns/1ps
module deleg_trap_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic        trap_irq = 1'b0;
    logic [3:0]  trap_code = '0;
    logic [31:0] trap_tval = '0;
    logic [31:0] trap_pc = '0;
    logic [1:0]  cur_priv = '0;
    logic        sret_req = 1'b0;
    logic        csr_we = 1'b0;
    logic [2:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [1:0]  tgt_priv;
    logic        mtrap_fire;
    logic        redir_valid;
    logic [31:0] redir_pc;
    logic [1:0]  new_priv;

    int n_chk = 0;
    int n_bad = 0;

    // model of the supervisor state, built from the requirements
    logic [31:0] m_edeleg, m_ideleg, m_stvec, m_sepc, m_scause, m_stval;
    logic        m_sie, m_spie, m_spp;

    always #2 clk = ~clk;

    deleg_trap_unit u_deleg_trap_unit (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_irq(trap_irq),
        .trap_code(trap_code), .trap_tval(trap_tval), .trap_pc(trap_pc),
        .cur_priv(cur_priv), .sret_req(sret_req), .csr_we(csr_we),
        .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .tgt_priv(tgt_priv), .mtrap_fire(mtrap_fire), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .new_priv(new_priv)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        csr_sel = sel;
        #0.2;
        v = csr_rdata;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
        step();
        csr_we = 1'b0;
    endtask

    function automatic logic [31:0] stat_word();
        return (32'(m_sie) << 1) | (32'(m_spie) << 5) | (32'(m_spp) << 8);
    endfunction

    task automatic check_state(input string tag);
        logic [31:0] v;
        rd(3'd5, v); chk({tag, " sepc"}, v, m_sepc);
        rd(3'd6, v); chk({tag, " scause"}, v, m_scause);
        rd(3'd7, v); chk({tag, " stval"}, v, m_stval);
        rd(3'd2, v); chk({tag, " sstatus"}, v, stat_word());
    endtask

    task automatic set_masks(input logic [31:0] e, input logic [31:0] i);
        logic [31:0] v;
        wr(3'd0, e); wr(3'd1, i);
        m_edeleg = e & 32'h0000_F7FF;
        m_ideleg = i & 32'h0000_FFFF;
        rd(3'd0, v); chk("R2 edeleg readback bit11 zero", v, m_edeleg);
        rd(3'd1, v); chk("R9 ideleg readback", v, m_ideleg);
    endtask

    // full sweep of privilege x kind x code
    task automatic sweep(input logic vec);
        for (int pi = 0; pi < 3; pi++) begin
            for (int ir = 0; ir < 2; ir++) begin
                for (int c = 0; c < 16; c++) begin
                    logic [1:0]  pv;
                    logic        dg;
                    logic [31:0] epc;
                    string       rq;
                    pv = (pi == 2) ? 2'd3 : 2'(pi);
                    // preset status bits from the code
                    m_sie = c[0]; m_spie = c[1]; m_spp = c[2];
                    wr(3'd2, stat_word());
                    dg = (pv != 2'd3) && (ir == 1 ? m_ideleg[c] : m_edeleg[c]);
                    rq = (pv == 2'd3) ? "R3" : ((ir == 1) ? "R1" : "R2");
                    trap_req = 1'b1; trap_irq = ir[0]; trap_code = 4'(c);
                    cur_priv = pv;
                    trap_pc = 32'h4000_0000 + (32'(c) << 4) + (32'(pi) << 12);
                    trap_tval = 32'hA000_0000 ^ (32'(c) << 8) ^ 32'(ir) ^ (32'(pi) << 20);
                    #0.2;
                    chk({rq, " tgt_priv"}, 32'(tgt_priv), dg ? 32'd1 : 32'd3);
                    chk({rq, " mtrap_fire"}, 32'(mtrap_fire), dg ? 32'd0 : 32'd1);
                    chk({rq, " redir_valid"}, 32'(redir_valid), 32'(dg));
                    chk({rq, " new_priv"}, 32'(new_priv), dg ? 32'd1 : 32'd3);
                    if (dg) begin
                        epc = (m_stvec & 32'hFFFF_FFFC) + ((vec && ir == 1) ? 32'(c) * 4 : 32'd0);
                        chk("R4 redir_pc entry", redir_pc, epc);
                    end
                    step();
                    trap_req = 1'b0;
                    if (dg) begin
                        m_spie = m_sie; m_sie = 1'b0; m_spp = (pv == 2'd1);
                        m_sepc = trap_pc;
                        m_scause = {ir[0], 27'd0, 4'(c)};
                        m_stval = trap_tval;
                        check_state("R5 R6 entry");
                        // return from the handler
                        sret_req = 1'b1;
                        #0.2;
                        chk("R7 sret redir_valid", 32'(redir_valid), 32'd1);
                        chk("R7 sret redir_pc", redir_pc, m_sepc);
                        chk("R7 sret new_priv", 32'(new_priv), 32'(m_spp));
                        step();
                        sret_req = 1'b0;
                        m_sie = m_spie; m_spie = 1'b1; m_spp = 1'b0;
                        check_state("R7 after sret");
                    end else begin
                        check_state("R3 no supervisor change");
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        m_edeleg = '0; m_ideleg = '0; m_stvec = '0; m_sepc = '0;
        m_scause = '0; m_stval = '0; m_sie = 0; m_spie = 0; m_spp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R9): all registers zero, idle outputs
        for (int s = 0; s < 8; s++) begin
            rd(3'(s), v);
            chk("R9 reset value", v, 32'd0);
        end
        #0.2;
        chk("R3 idle mtrap_fire", 32'(mtrap_fire), 32'd0);
        chk("R7 idle redir_valid", 32'(redir_valid), 32'd0);

        // R9 write masks
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); chk("R9 sstatus mask", v, 32'h0000_0122);
        wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); chk("R9 sie mask", v, 32'h0000_0222);
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, v); chk("R9 stvec bit1", v, 32'hFFFF_FFFD);
        wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); chk("R9 sepc bit0", v, 32'hFFFF_FFFE);
        wr(3'd6, 32'h8000_0005); rd(3'd6, v); chk("R9 scause", v, 32'h8000_0005);
        wr(3'd7, 32'h1234_5678); rd(3'd7, v); chk("R9 stval", v, 32'h1234_5678);
        m_sepc = 32'hFFFF_FFFE; m_scause = 32'h8000_0005; m_stval = 32'h1234_5678;

        // sweep 1: direct mode
        wr(3'd4, 32'h0000_1200); m_stvec = 32'h0000_1200;
        set_masks(32'h0000_0B35, 32'h0000_0222);
        sweep(1'b0);

        // sweep 2: vectored mode, different masks
        wr(3'd4, 32'h0000_3303); m_stvec = 32'h0000_3301;
        rd(3'd4, v); chk("R9 stvec vectored readback", v, m_stvec);
        set_masks(32'h0000_F8CA, 32'h0000_FDDD);
        sweep(1'b1);

        // R8: trap and return together from supervisor level
        set_masks(32'h0000_0100, 32'h0000_0000);
        m_sie = 1; m_spie = 0; m_spp = 0;
        wr(3'd2, stat_word());
        trap_req = 1; sret_req = 1; trap_irq = 0; trap_code = 4'd8; cur_priv = 2'd1;
        trap_pc = 32'h5000_0040; trap_tval = 32'h0000_0BAD;
        #0.2;
        chk("R8 redir_pc is entry", redir_pc, 32'h0000_3300);
        chk("R8 new_priv", 32'(new_priv), 32'd1);
        step();
        trap_req = 0; sret_req = 0;
        m_spie = 1; m_sie = 0; m_spp = 1;
        m_sepc = 32'h5000_0040; m_scause = 32'd8; m_stval = 32'h0000_0BAD;
        check_state("R8 trap wins");

        // R10: CSR write to sepc in the same cycle as a delegated trap
        cur_priv = 2'd0; trap_req = 1; trap_pc = 32'h6000_0080; trap_tval = 32'h77;
        csr_we = 1; csr_sel = 3'd5; csr_wdata = 32'h5555_5550;
        step();
        trap_req = 0; csr_we = 0;
        rd(3'd5, v); chk("R10 sepc trap wins", v, 32'h6000_0080);

        // R2: machine-level ecall bit cannot be set
        wr(3'd0, 32'h0000_0800); rd(3'd0, v); chk("R2 ecall-M bit hardwired", v, 32'd0);
        trap_req = 1; trap_irq = 0; trap_code = 4'd11; cur_priv = 2'd1;
        #0.2;
        chk("R2 code 11 goes to machine", 32'(tgt_priv), 32'd3);
        step();
        trap_req = 0;

        summary();
        $finish;
    end
endmodule